// File: doc/BRIEF.md
# Scaled Effective Address Generator

This block turns a decoded memory-access descriptor into a 32-bit byte address. The descriptor carries a 3-bit mode, a base register value, an index register value, a 3-bit scale code, a 12-bit short offset and a 32-bit long displacement. The block combines the operands that the mode selects and presents the sum, wrapped modulo 2^32, one register stage later.

Transfers on both sides use a valid/ready handshake. The single result register loads whenever downstream is ready or the register is empty, so back-to-back descriptors stream at one per cycle. A scale code beyond the supported range in an indexed mode is reported on an illegal flag, and the address is then zero.

Top module: `eag_top`

## Requirements
- R1: While reset is held, and in the cycles after release until the first accepted descriptor, `out_valid` is 0. Once the internal reset has been released (a few cycles after `rst_n` rises), `in_ready` is 1.
- R2: Mode 0 yields the short offset zero-extended to 32 bits (offset 0x800 gives 0x00000800). Base, index and displacement have no effect.
- R3: Mode 1 yields the long displacement. Mode 2 yields the base register value.
- R4: Mode 3 yields base plus the zero-extended short offset. Mode 4 yields base plus the long displacement.
- R5: Scale codes 0 to 4 multiply the index by 1, 2, 4, 8 or 16. Mode 5 yields base plus scaled index. Mode 6 yields scaled index plus displacement. Mode 7 yields base plus scaled index plus displacement.
- R6: All sums and the index scaling wrap modulo 2^32.
- R7: In modes 5, 6 and 7, a scale code of 5, 6 or 7 sets `out_illegal` to 1 and forces `out_addr` to 0.
- R8: In modes 0 to 4, the scale code has no effect: `out_illegal` is 0 and the address is as in R2 to R4.
- R9: A descriptor is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 whenever no result is held or `out_ready` is 1. After each edge where `in_ready` was 1, `out_valid` equals the `in_valid` of that edge. Results leave in acceptance order.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_addr`, `out_illegal` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally in step with the clock |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_mode | input | 3 | Addressing mode 0..7 |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_scale | input | 3 | Index shift amount; 0..4 legal |
| in_off12 | input | 12 | Short offset, zero-extended |
| in_disp | input | 32 | Long displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Effective address |
| out_illegal | output | 1 | Scale code out of range in an indexed mode |

## Verification
The properties assume that mode, scale and displacement are at known values in every cycle where `in_valid` is 1, and that `out_ready` is never unknown once reset is released. The bench drives every descriptor field on each valid cycle. It changes inputs only just after a rising edge, and it keeps `out_ready` at a defined 0 or 1 throughout, including during the paced-ready and stall phases.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    EA_ABS_SHORT    = 3'd0,
    EA_ABS_LONG     = 3'd1,
    EA_REG          = 3'd2,
    EA_REG_SHORT    = 3'd3,
    EA_REG_LONG     = 3'd4,
    EA_REG_IDX      = 3'd5,
    EA_IDX_LONG     = 3'd6,
    EA_REG_IDX_LONG = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    OFS_NONE  = 2'd0,
    OFS_SHORT = 2'd1,
    OFS_LONG  = 2'd2
  } ofs_sel_e;

  typedef struct packed {
    logic     use_base;
    logic     use_index;
    ofs_sel_e ofs;
  } ea_sel_t;

  function automatic ea_sel_t decode_mode(input ea_mode_e m);
    ea_sel_t s;
    s.use_base  = 1'b0;
    s.use_index = 1'b0;
    s.ofs       = OFS_NONE;
    case (m)
      EA_ABS_SHORT:    s.ofs = OFS_SHORT;
      EA_ABS_LONG:     s.ofs = OFS_LONG;
      EA_REG:          s.use_base = 1'b1;
      EA_REG_SHORT: begin
        s.use_base = 1'b1;
        s.ofs      = OFS_SHORT;
      end
      EA_REG_LONG: begin
        s.use_base = 1'b1;
        s.ofs      = OFS_LONG;
      end
      EA_REG_IDX: begin
        s.use_base  = 1'b1;
        s.use_index = 1'b1;
      end
      EA_IDX_LONG: begin
        s.use_index = 1'b1;
        s.ofs       = OFS_LONG;
      end
      default: begin
        s.use_base  = 1'b1;
        s.use_index = 1'b1;
        s.ofs       = OFS_LONG;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/eag_rst_sync.sv
module eag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/eag_scaler.sv
module eag_scaler #(
  parameter int W         = 32,
  parameter int SW        = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic [W-1:0]  index,
  input  logic [SW-1:0] code,
  output logic [W-1:0]  scaled,
  output logic          out_of_range
);

  localparam logic [SW-1:0] LIMIT = SW'(MAX_SHIFT);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = index;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = code[k] ? (stg[k] << (2**k)) : stg[k];
  end

  assign scaled       = stg[SW];
  assign out_of_range = (code > LIMIT);

endmodule

// File: rtl/eag_sum.sv
module eag_sum
  import eag_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 12
) (
  input  ea_sel_t          sel,
  input  logic             illegal,
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     scaled_index,
  input  logic [OFF_W-1:0] off_short,
  input  logic [W-1:0]     disp,
  output logic [W-1:0]     addr
);

  localparam int EXT_W = W - OFF_W;

  logic [W-1:0] op_base;
  logic [W-1:0] op_index;
  logic [W-1:0] op_ofs;
  logic [W-1:0] total;

  always_comb begin
    op_base  = sel.use_base  ? base         : '0;
    op_index = sel.use_index ? scaled_index : '0;
    case (sel.ofs)
      OFS_SHORT: op_ofs = {{EXT_W{1'b0}}, off_short};
      OFS_LONG:  op_ofs = disp;
      default:   op_ofs = '0;
    endcase
    total = op_base + op_index + op_ofs;
    addr  = illegal ? '0 : total;
  end

endmodule

// File: rtl/eag_outreg.sv
module eag_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_addr,
  input  logic         in_illegal,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_addr,
  output logic         out_illegal
);

  logic         valid_q;
  logic         valid_d;
  logic         load;
  logic         data_en;
  logic [W-1:0] addr_q;
  logic         ill_q;

  always_comb begin
    load     = rst_n & (~valid_q | out_ready);
    data_en  = load & in_valid;
    valid_d  = load ? in_valid : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      addr_q <= in_addr;
      ill_q  <= in_illegal;
    end
  end

  assign in_ready    = load;
  assign out_valid   = valid_q;
  assign out_addr    = addr_q;
  assign out_illegal = ill_q;

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int SCALE_W     = 3,
  parameter int MAX_SHIFT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_mode,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [ADDR_W-1:0]  in_index,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [OFF_W-1:0]   in_off12,
  input  logic [ADDR_W-1:0]  in_disp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               out_illegal
);

  logic              rst_q_n;
  ea_sel_t           sel;
  logic [ADDR_W-1:0] scaled_index;
  logic              scale_bad;
  logic              illegal;
  logic [ADDR_W-1:0] addr_c;

  eag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign sel     = decode_mode(ea_mode_e'(in_mode));
  assign illegal = sel.use_index & scale_bad;

  eag_scaler #(.W(ADDR_W), .SW(SCALE_W), .MAX_SHIFT(MAX_SHIFT)) u_scaler (
    .index        (in_index),
    .code         (in_scale),
    .scaled       (scaled_index),
    .out_of_range (scale_bad)
  );

  eag_sum #(.W(ADDR_W), .OFF_W(OFF_W)) u_sum (
    .sel          (sel),
    .illegal      (illegal),
    .base         (in_base),
    .scaled_index (scaled_index),
    .off_short    (in_off12),
    .disp         (in_disp),
    .addr         (addr_c)
  );

  eag_outreg #(.W(ADDR_W)) u_outreg (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_addr     (addr_c),
    .in_illegal  (illegal),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_illegal (out_illegal)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int W     = 32,
  parameter int OFF_W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_mode,
  input logic [W-1:0] in_disp,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_addr,
  input logic         out_illegal
);

  logic take;
  assign take = in_valid & in_ready;

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (out_valid == $past(in_valid))); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_illegal))); // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_addr == '0)); // R7

  AST_PLAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mode < 3'd5)) |=> !out_illegal); // R8

  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mode == 3'd0)) |=> (out_addr[W-1:OFF_W] == '0)); // R2

  AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mode == 3'd1)) |=> (out_addr == $past(in_disp))); // R3

endmodule

bind eag_top eag_checker #(.W(ADDR_W), .OFF_W(OFF_W)) u_eag_checker (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .in_disp     (in_disp),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_illegal (out_illegal)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [31:0] in_base = '0;
  logic [31:0] in_index = '0;
  logic [2:0]  in_scale = '0;
  logic [11:0] in_off12 = '0;
  logic [31:0] in_disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_illegal;

  always #4 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_index(in_index),
    .in_scale(in_scale), .in_off12(in_off12), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_illegal(out_illegal)
  );

  typedef struct {
    logic [31:0] addr;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    pace_ready = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [31:0] b,
                                 input logic [31:0] x, input logic [2:0] s,
                                 input logic [11:0] o, input logic [31:0] d,
                                 input string tag);
    exp_t e;
    logic [31:0] sx;
    logic [31:0] oz;
    sx = x * (32'd1 << s);
    oz = {20'h0, o};
    e.tag = tag;
    e.ill = 1'b0;
    if (m >= 3'd5 && s > 3'd4) begin
      e.ill  = 1'b1;
      e.addr = 32'h0;
    end else begin
      case (m)
        3'd0: e.addr = oz;
        3'd1: e.addr = d;
        3'd2: e.addr = b;
        3'd3: e.addr = b + oz;
        3'd4: e.addr = b + d;
        3'd5: e.addr = b + sx;
        3'd6: e.addr = sx + d;
        default: e.addr = b + sx + d;
      endcase
    end
    return e;
  endfunction

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic drive(input logic [2:0] m, input logic [31:0] b,
                       input logic [31:0] x, input logic [2:0] s,
                       input logic [11:0] o, input logic [31:0] d,
                       input string tag);
    in_mode = m; in_base = b; in_index = x; in_scale = s;
    in_off12 = o; in_disp = d; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    sb.push_back(model(m, b, x, s, o, d, tag));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(posedge clk);
    #1;
    check(sb.size() == 0, "R9", "results drained", sb.size(), 0);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected result", out_addr, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_addr == e.addr, e.tag, "address", out_addr, e.addr);
          check(out_illegal == e.ill, e.tag, "illegal flag", {31'h0, out_illegal}, {31'h0, e.ill});
        end
      end
    end
  end

  // Paced downstream ready
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (pace_ready) out_ready = (cyc % 3) != 0;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_t ea;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid in reset", {31'h0, out_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 1);

    // R2: short absolute, zero-extended
    drive(3'd0, 32'hFFFF_0000, 32'h1234, 3'd0, 12'hFFF, 32'h5555_AAAA, "R2");
    drive(3'd0, 32'h0, 32'h0, 3'd2, 12'h800, 32'h0, "R2");
    // R3
    drive(3'd1, 32'h1111_1111, 32'h2, 3'd1, 12'h123, 32'hDEAD_BEEF, "R3");
    drive(3'd2, 32'h1234_5678, 32'h9, 3'd3, 12'hABC, 32'h7777_0000, "R3");
    // R4
    drive(3'd3, 32'h0000_1000, 32'h0, 3'd0, 12'hABC, 32'h0, "R4");
    drive(3'd4, 32'h1000_0000, 32'h0, 3'd0, 12'h0, 32'h0234_5678, "R4");
    // R5: every legal scale in each indexed mode
    for (int m = 5; m <= 7; m++) begin
      for (int s = 0; s <= 4; s++) begin
        drive(3'(m), 32'h0001_0000, 32'h0000_0123, 3'(s), 12'h0, 32'h0000_0040, "R5");
      end
    end
    // R6: wrap-around
    drive(3'd3, 32'hFFFF_FFF0, 32'h0, 3'd0, 12'h020, 32'h0, "R6");
    drive(3'd7, 32'hF000_0000, 32'h9000_0001, 3'd4, 12'h0, 32'h1000_0005, "R6");
    drive(3'd4, 32'h8000_0000, 32'h0, 3'd0, 12'h0, 32'h8000_0001, "R6");
    // R7: out-of-range scale in indexed modes
    for (int m = 5; m <= 7; m++) begin
      for (int s = 5; s <= 7; s++) begin
        drive(3'(m), 32'h4000_0000, 32'h10, 3'(s), 12'h0, 32'h88, "R7");
      end
    end
    // R8: scale ignored in plain modes
    for (int m = 0; m <= 4; m++) begin
      drive(3'(m), 32'h0300_0000, 32'hFFFF_FFFF, 3'd7, 12'h456, 32'h0000_0100, "R8");
    end
    drain();
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after drain", {31'h0, out_valid}, 0);
    check(in_ready == 1'b1, "R9", "in_ready when empty", {31'h0, in_ready}, 1);
    @(posedge clk);
    #1;

    // R9: streaming against paced ready, mixed patterns
    pace_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r1, r2, r3;
      lfsr = next_rand(lfsr); r1 = lfsr;
      lfsr = next_rand(lfsr); r2 = lfsr;
      lfsr = next_rand(lfsr); r3 = lfsr;
      drive(r1[2:0], r2, r3, (r1[5:3] > 3'd4 && r1[6]) ? r1[5:3] : 3'(r1[5:3] % 5),
            r1[19:8], r3 ^ r2, "R9");
    end
    drain();
    pace_ready = 1'b0;
    @(posedge clk);
    #1;
    out_ready = 1'b1;

    // R10: stall holds result and blocks input
    out_ready = 1'b0;
    ea = model(3'd7, 32'h0000_2000, 32'h0000_0010, 3'd3, 12'h0, 32'h0000_0004, "R10");
    drive(3'd7, 32'h0000_2000, 32'h0000_0010, 3'd3, 12'h0, 32'h0000_0004, "R10");
    fork
      drive(3'd6, 32'h0, 32'h0000_0001, 3'd6, 12'h0, 32'h0000_0010, "R10");
    join_none
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R10", "out_valid held", {31'h0, out_valid}, 1);
      check(in_ready == 1'b0, "R10", "in_ready blocked", {31'h0, in_ready}, 0);
      check(out_addr == ea.addr, "R10", "address held", out_addr, ea.addr);
    end
    @(posedge clk);
    #1;
    out_ready = 1'b1;
    wait fork;
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule